// File: doc/BRIEF.md
# Float Absolute-Value Execute Unit

This block is one execution slice of a floating-point coprocessor. It owns eight 32-bit single-precision registers and a seven-bit status-flag register. It takes an instruction word as two 16-bit halves. When the word encodes the absolute-value operation, the block reads the chosen source register and clears its sign bit. It writes the result to the chosen destination register and updates the zero and negative flags. The whole operation completes in one clock.

A word that does not match the encoding is rejected. Rejection raises a one-cycle illegal indication and leaves all state untouched. A preload port lets a test environment seed any register or the whole flag register while no instruction is presented. A combinational read-back port shows any register, and the flag register is always visible.

The instruction input carries no back-pressure. The unit accepts a word on every cycle in which `ins_valid` is high. It has no ready signal, so the producer may issue on every clock. Control pins (preload, read-back, flags, illegal) are plain level signals.

Top module: `fabs_unit`

## Requirements
- R1: While reset is asserted, all eight registers and all seven flags read zero and `illegal_o` is low.
- R2: A word is legal when `ins_valid` is high, `ins_lo` equals 16'hE695 and `ins_hi[15:6]` is zero. For a legal word, `ins_hi[5:3]` names the source register and `ins_hi[2:0]` names the destination register.
- R3: A legal word writes the destination at the accepting clock edge. The value written is the source with bit 31 cleared and bits 30:0 copied unchanged, including NaN and infinity patterns.
- R4: When the source and the destination are the same register, the result is computed from the value held before the edge.
- R5: Flag bit 0 (negative) is cleared by every legal word.
- R6: Flag bit 1 (zero) is set by a legal word when result bits 30:23 are all zero, whatever the mantissa holds. It is cleared otherwise.
- R7: A legal word leaves flag bits 6:2 unchanged. These bits are, in order from bit 2 upward: integer-negative, integer-zero, test, latched-overflow and latched-underflow.
- R8: A word presented with `ins_valid` high that is not legal raises `illegal_o` in the following cycle only. It changes no register and no flag.
- R9: With `ins_valid` low, the instruction halves are ignored and `illegal_o` is low in the next cycle.
- R10: With `ins_valid` low, `pre_reg_en` writes `pre_reg_data` into register `pre_reg_idx`, and `pre_flag_en` loads `pre_flag_data` into the flags, both at the clock edge. While `ins_valid` is high, both preload strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Instruction word present this cycle |
| ins_lo | input | 16 | Low instruction half (operation code) |
| ins_hi | input | 16 | High instruction half (register fields) |
| pre_reg_en | input | 1 | Register preload strobe |
| pre_reg_idx | input | 3 | Register preload index |
| pre_reg_data | input | 32 | Register preload value |
| pre_flag_en | input | 1 | Flag preload strobe |
| pre_flag_data | input | 7 | Flag preload value |
| rd_idx | input | 3 | Read-back register index |
| rd_data | output | 32 | Read-back value of register `rd_idx` |
| flags_o | output | 7 | Status flags |
| illegal_o | output | 1 | Rejected word seen in previous cycle |

## Verification
A register-file or flag fault surfaces on `rd_data` or `flags_o` in the cycle right after the edge that caused it. The bench compares all eight registers, the flags and `illegal_o` against its model after every clock. A wrong write address therefore corrupts a register that is inspected within half a clock. A sign bit that is not cleared, or a zero flag taken from the mantissa, shows as a mismatch on the first operand with a negative sign or a zero exponent and non-zero mantissa. A decode that accepts a stray word shows as a changed register together with a missing `illegal_o` pulse, one cycle later.

// File: rtl/fabs_pkg.sv
`timescale 1ns/1ps
package fabs_pkg;
  localparam int unsigned HALF_W   = 16;
  localparam logic [HALF_W-1:0] OPC_ABS = 16'hE695;
  localparam int unsigned FLAG_W   = 7;
  localparam int unsigned EXP_W    = 8;
  // flag bit positions
  localparam int unsigned FL_NEG   = 0;
  localparam int unsigned FL_ZERO  = 1;
  localparam int unsigned FL_INEG  = 2;
  localparam int unsigned FL_IZERO = 3;
  localparam int unsigned FL_TEST  = 4;
  localparam int unsigned FL_OVF   = 5;
  localparam int unsigned FL_UNF   = 6;
endpackage

// File: rtl/fabs_decode.sv
`timescale 1ns/1ps
module fabs_decode
  import fabs_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic              valid,
  input  logic [HALF_W-1:0] lo,
  input  logic [HALF_W-1:0] hi,
  output logic              legal,
  output logic              reject,
  output logic [IDX_W-1:0]  src,
  output logic [IDX_W-1:0]  dst
);
  localparam int unsigned FIELD_W = 2 * IDX_W;

  logic opc_hit;
  logic pad_clear;

  assign opc_hit   = (lo == OPC_ABS);
  assign pad_clear = (hi[HALF_W-1:FIELD_W] == '0);
  assign legal     = valid & opc_hit & pad_clear;
  assign reject    = valid & ~(opc_hit & pad_clear);
  assign src       = hi[FIELD_W-1:IDX_W];
  assign dst       = hi[IDX_W-1:0];
endmodule

// File: rtl/fabs_regfile.sv
`timescale 1ns/1ps
module fabs_regfile #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       waddr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [IDX_W-1:0]       raddr_a,
  output logic [DATA_W-1:0]      rdata_a,
  input  logic [IDX_W-1:0]       raddr_b,
  output logic [DATA_W-1:0]      rdata_b,
  output logic [NREG*DATA_W-1:0] flat
);
  logic [DATA_W-1:0] ent [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent[g] <= '0;
      else if (we && (waddr == IDX_W'(g)))
        ent[g] <= wdata;
    end
    assign flat[g*DATA_W +: DATA_W] = ent[g];
  end

  assign rdata_a = ent[raddr_a];
  assign rdata_b = ent[raddr_b];
endmodule

// File: rtl/fabs_status.sv
`timescale 1ns/1ps
module fabs_status
  import fabs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec,
  input  logic              zero_in,
  input  logic              load_en,
  input  logic [FLAG_W-1:0] load_val,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] nxt;

  always_comb begin
    nxt = flags;
    if (exec) begin
      nxt[FL_NEG]  = 1'b0;
      nxt[FL_ZERO] = zero_in;
    end else if (load_en) begin
      nxt = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end
endmodule

// File: rtl/fabs_unit.sv
`timescale 1ns/1ps
module fabs_unit
  import fabs_pkg::*;
#(
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [HALF_W-1:0] ins_lo,
  input  logic [HALF_W-1:0] ins_hi,
  input  logic              pre_reg_en,
  input  logic [IDX_W-1:0]  pre_reg_idx,
  input  logic [DATA_W-1:0] pre_reg_data,
  input  logic              pre_flag_en,
  input  logic [FLAG_W-1:0] pre_flag_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [FLAG_W-1:0] flags_o,
  output logic              illegal_o
);
  localparam int unsigned SIGN_B = DATA_W - 1;
  localparam int unsigned EXP_HI = DATA_W - 2;

  logic                   legal, reject;
  logic [IDX_W-1:0]       src, dst;
  logic [DATA_W-1:0]      src_val, result;
  logic                   res_zero;
  logic                   we;
  logic [IDX_W-1:0]       waddr;
  logic [DATA_W-1:0]      wdata;
  logic [NREG*DATA_W-1:0] rf_flat;
  logic                   pre_ok_reg, pre_ok_flag;

  fabs_decode #(.IDX_W(IDX_W)) u_dec (
    .valid (ins_valid),
    .lo    (ins_lo),
    .hi    (ins_hi),
    .legal (legal),
    .reject(reject),
    .src   (src),
    .dst   (dst)
  );

  // sign stripped, everything else passes
  assign result   = {1'b0, src_val[SIGN_B-1:0]};
  assign res_zero = (result[EXP_HI -: EXP_W] == '0);

  assign pre_ok_reg  = pre_reg_en  & ~ins_valid;
  assign pre_ok_flag = pre_flag_en & ~ins_valid;

  assign we    = legal | pre_ok_reg;
  assign waddr = legal ? dst    : pre_reg_idx;
  assign wdata = legal ? result : pre_reg_data;

  fabs_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (we),
    .waddr  (waddr),
    .wdata  (wdata),
    .raddr_a(src),
    .rdata_a(src_val),
    .raddr_b(rd_idx),
    .rdata_b(rd_data),
    .flat   (rf_flat)
  );

  fabs_status u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec    (legal),
    .zero_in (res_zero),
    .load_en (pre_ok_flag),
    .load_val(pre_flag_data),
    .flags   (flags_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_o <= 1'b0;
    else        illegal_o <= reject;
  end
endmodule

// File: rtl/fabs_unit_chk.sv
`timescale 1ns/1ps
module fabs_unit_chk
  import fabs_pkg::*;
#(
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ins_valid,
  input logic [HALF_W-1:0]      ins_lo,
  input logic [HALF_W-1:0]      ins_hi,
  input logic [FLAG_W-1:0]      flags_o,
  input logic                   illegal_o,
  input logic [NREG*DATA_W-1:0] rf_flat
);
  logic             c_legal;
  logic [IDX_W-1:0] c_src, c_dst;

  assign c_legal = ins_valid && (ins_lo == 16'hE695) && (ins_hi[15:2*IDX_W] == '0);
  assign c_src   = ins_hi[2*IDX_W-1:IDX_W];
  assign c_dst   = ins_hi[IDX_W-1:0];

  function automatic logic [DATA_W-1:0] ent(input logic [NREG*DATA_W-1:0] f,
                                            input logic [IDX_W-1:0] i);
    return f[i*DATA_W +: DATA_W];
  endfunction

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (rf_flat == '0 && flags_o == '0 && !illegal_o));

  // R3
  sign_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_legal |=> !ent(rf_flat, $past(c_dst))[DATA_W-1]);

  // R4
  payload_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_legal |=> ent(rf_flat, $past(c_dst))[DATA_W-2:0] ==
                $past(ent(rf_flat, c_src))[DATA_W-2:0]);

  // R5
  neg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_legal |=> !flags_o[FL_NEG]);

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_legal |=> flags_o[FL_ZERO] ==
                (ent(rf_flat, $past(c_dst))[DATA_W-2 -: EXP_W] == '0));

  // R7
  upper_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_legal |=> flags_o[FLAG_W-1:FL_INEG] == $past(flags_o[FLAG_W-1:FL_INEG]));

  // R8
  illegal_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !c_legal) |=> illegal_o);

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !c_legal) |=> ($stable(rf_flat) && $stable(flags_o)));

  // R9
  illegal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> !illegal_o);
endmodule

bind fabs_unit fabs_unit_chk #(.NREG(NREG), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ins_valid(ins_valid),
  .ins_lo   (ins_lo),
  .ins_hi   (ins_hi),
  .flags_o  (flags_o),
  .illegal_o(illegal_o),
  .rf_flat  (rf_flat)
);

// File: tb/test_fabs_unit.sv
`timescale 1ns/1ps
module test_fabs_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic [15:0] ins_lo = '0, ins_hi = '0;
  logic        pre_reg_en = 1'b0;
  logic [2:0]  pre_reg_idx = '0;
  logic [31:0] pre_reg_data = '0;
  logic        pre_flag_en = 1'b0;
  logic [6:0]  pre_flag_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [6:0]  flags_o;
  logic        illegal_o;

  always #4 clk = ~clk;

  fabs_unit i_fabs_unit (.*);

  logic [31:0] m_reg [8];
  logic [6:0]  m_flags;
  logic        m_ill;
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #0.1;
      cmp(tag, $sformatf("reg%0d", i), rd_data, m_reg[i]);
    end
    cmp(tag, "flags", 32'(flags_o), 32'(m_flags));
    cmp(tag, "illegal", 32'(illegal_o), 32'(m_ill));
  endtask

  // one clock: drive, let the edge happen, update model, compare
  task automatic step(string tag, bit v, logic [15:0] lo, logic [15:0] hi,
                      bit pen, logic [2:0] pidx, logic [31:0] pdat,
                      bit fen, logic [6:0] fdat);
    logic [31:0] r;
    ins_valid = v; ins_lo = lo; ins_hi = hi;
    pre_reg_en = pen; pre_reg_idx = pidx; pre_reg_data = pdat;
    pre_flag_en = fen; pre_flag_data = fdat;
    @(posedge clk);
    if (v && lo == 16'hE695 && hi[15:6] == 10'd0) begin
      r = m_reg[hi[5:3]] & 32'h7FFF_FFFF;
      m_reg[hi[2:0]] = r;
      m_flags[0] = 1'b0;
      m_flags[1] = (r[30:23] == 8'd0);
      m_ill = 1'b0;
    end else if (v) begin
      m_ill = 1'b1;
    end else begin
      m_ill = 1'b0;
      if (pen) m_reg[pidx] = pdat;
      if (fen) m_flags = fdat;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic op(string tag, int s, int d);
    step(tag, 1, 16'hE695, 16'((s << 3) | d), 0, 0, 0, 0, 0);
  endtask
  task automatic load(string tag, int i, logic [31:0] v);
    step(tag, 0, 16'h0, 16'h0, 1, 3'(i), v, 0, 0);
  endtask
  task automatic idle(string tag);
    step(tag, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_flags = '0; m_ill = 0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    idle("R1");
    // R10 preloads
    load("R10", 1, 32'hC000_0000);
    load("R10", 0, 32'h40A0_0000);
    load("R10", 2, 32'h0000_0000);
    load("R10", 3, 32'h8000_0001);
    load("R10", 4, 32'hFFC0_0001);
    load("R10", 5, 32'hFF80_0000);
    load("R10", 6, 32'h807F_FFFF);
    step("R10", 0, 0, 0, 0, 0, 0, 1, 7'b111_1111);
    // R3/R4 same register, -2.0
    op("R4", 1, 1);
    op("R3", 0, 7);
    op("R6", 2, 1);
    op("R6", 3, 3);
    op("R3", 4, 4);
    op("R3", 5, 2);
    op("R6", 6, 0);
    op("R2", 7, 6);
    // R7 upper flags preserved with a different pattern
    step("R7", 0, 0, 0, 0, 0, 0, 1, 7'b101_0011);
    op("R7", 1, 5);
    op("R5", 3, 3);
    // R8 illegal words
    load("R8", 4, 32'hBF80_0000);
    step("R8", 1, 16'hE694, 16'h0024, 0, 0, 0, 0, 0);
    step("R8", 1, 16'hE695, 16'h8024, 0, 0, 0, 0, 0);
    step("R8", 1, 16'hE695, 16'h0064, 0, 0, 0, 0, 0);
    idle("R8");
    // R9 garbage with valid low
    step("R9", 0, 16'hE695, 16'h0020, 0, 0, 0, 0, 0);
    // R10 preload ignored while valid
    step("R10", 1, 16'hE695, 16'h0024, 1, 3'd6, 32'h1234_5678, 1, 7'b010_1010);
    step("R10", 1, 16'h0000, 16'h0000, 1, 3'd6, 32'h1234_5678, 1, 7'b010_1010);
    // mixed random stream
    for (int k = 0; k < 300; k++) begin
      int unsigned u;
      u = $urandom;
      case (u % 5)
        0: load("R10", int'(u >> 8) % 8, $urandom);
        1: step("R7", 0, 0, 0, 0, 0, 0, 1, 7'($urandom));
        2: step("R8", 1, (u[10]) ? 16'hE695 : 16'($urandom), 16'($urandom), 0, 0, 0, 0, 0);
        default: op("R3", int'(u >> 4) % 8, int'(u >> 12) % 8);
      endcase
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule